// File: doc/BRIEF.md
# Shared-Counter Wilkinson Conversion Capture

This block is the digital half of a ramp-type analog-to-digital converter in which many channels share one counter and one rising ramp. A start pulse launches a conversion. A counter then advances by one every clock while the ramp rises, and it is sent to every channel as a Gray code, so that exactly one bit changes from one cycle to the next. Each channel has a comparator that flips when the ramp passes the voltage held on that channel. The first rising edge of that comparator makes the channel keep the counter value of that moment. When the counter has reached full scale, the block raises an end-of-ramp flag. The codes that were kept can then be read one at a time through a select input, already converted back to plain binary.

A channel whose comparator never rises during the ramp reads back as full scale. The comparator inputs are taken to be synchronous to the clock already. The ramp, the comparators and the hold circuits are outside the block.

The controller has three states. `ST_IDLE` is entered at reset. A start in `ST_IDLE` takes the transition *launch* to `ST_RAMP`. `ST_RAMP` holds while the counter is below full scale. The transition *finish* goes to `ST_DONE` on the clock after the counter reaches full scale. `ST_DONE` holds until a start takes the transition *relaunch* back to `ST_RAMP`. A start while in `ST_RAMP` is ignored.

Top module: `wilkinson_capture`

## Requirements
- R1: After reset `ramp_active` and `end_of_ramp` are 0 and every in-range channel reads back the full-scale code (all ones).
- R2: A `start_ramp` high at a clock edge in `ST_IDLE` or `ST_DONE` makes `ramp_active` 1, `end_of_ramp` 0 and `count_gray` 0 after that edge. Every channel code reads full scale until a capture occurs.
- R3: While `ramp_active` is 1, the binary counter advances by one per clock, starting from 0. `count_gray` always equals n XOR (n >> 1) of the binary count n, so consecutive values differ in exactly one bit.
- R4: The counter stops at full scale (2^WIDTH-1) and does not wrap. One clock after `count_gray` first shows full scale, `ramp_active` falls and `end_of_ramp` rises.
- R5: A channel whose `cmp_in` bit is 0 in one cycle and 1 in the next cycle of `ST_RAMP` keeps the count shown in the cycle where the bit is 1. This applies up to and including the full-scale cycle. The code is read back in binary on `rd_code` when `rd_sel` equals the channel index.
- R6: Only the first rising edge of a channel's comparator after a start is kept; later edges in the same ramp leave its code unchanged.
- R7: A channel with no comparator rising edge during the ramp reads back full scale at end of ramp.
- R8: A `start_ramp` pulse while in `ST_RAMP` has no effect: the count keeps advancing and no code is cleared.
- R9: `end_of_ramp` and the kept codes hold steady in `ST_DONE` until the next start.
- R10: A `rd_sel` value at or above NCH reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_ramp | input | 1 | Start-conversion pulse |
| cmp_in | input | NCH | Per-channel ramp comparator outputs, synchronous |
| rd_sel | input | max(1, clog2(NCH)) | Channel index for read-back |
| ramp_active | output | 1 | High in `ST_RAMP` |
| end_of_ramp | output | 1 | High in `ST_DONE` |
| count_gray | output | WIDTH | Shared counter value in Gray code |
| rd_code | output | WIDTH | Binary code of the selected channel |

## Verification
Every registered result is due one edge after the stimulus that causes it:
- The count and `ramp_active` change on the edge that samples the start.
- A capture becomes visible on the edge after the cycle in which the comparator is first high.
- `end_of_ramp` rises on the edge after the full-scale count appears.

The bench drives all inputs on the falling clock edge and samples results just after that same falling edge. Each check therefore sees the state left by the previous rising edge, and the bench's cycle index matches the count directly. The read-back path is combinational, so `rd_sel` sweeps are sampled 1 ns after the select changes, with no clock edge in between. The sweep uses a small configuration (5 channels, 5 bits) and moves a channel's capture point through every count from 0 to full scale.

// File: rtl/wc_pkg.sv
package wc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_DONE = 2'd2
    } wc_state_e;
endpackage

// File: rtl/wc_ramp_fsm.sv
module wc_ramp_fsm
    import wc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      count_at_max,
    output wc_state_e state,
    output logic      launch,
    output logic      advance,
    output logic      capture_en
);
    wc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)        state_d = ST_RAMP;  // launch
            ST_RAMP: if (count_at_max) state_d = ST_DONE;  // finish
            ST_DONE: if (start)        state_d = ST_RAMP;  // relaunch
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        launch     = 1'b0;
        advance    = 1'b0;
        capture_en = 1'b0;
        unique case (state_q)
            ST_IDLE: launch = start;
            ST_RAMP: begin
                advance    = !count_at_max;
                capture_en = 1'b1;
            end
            ST_DONE: launch = start;
            default: launch = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/wc_gray_counter.sv
module wc_gray_counter #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [WIDTH-1:0] gray,
    output logic             at_max
);
    localparam logic [WIDTH-1:0] BIN_MAX = {WIDTH{1'b1}};

    logic [WIDTH-1:0] bin_q, bin_d;

    always_comb begin
        bin_d = bin_q;
        if (clear)        bin_d = '0;
        else if (advance) bin_d = bin_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q <= '0;
            gray  <= '0;
        end else begin
            bin_q <= bin_d;
            gray  <= bin_d ^ (bin_d >> 1);
        end
    end

    assign at_max = (bin_q == BIN_MAX);
endmodule

// File: rtl/wc_channel_latch.sv
module wc_channel_latch #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture_en,
    input  logic             cmp,
    input  logic [WIDTH-1:0] gray_in,
    output logic [WIDTH-1:0] code_gray
);
    localparam logic [WIDTH-1:0] GRAY_FULL = {1'b1, {(WIDTH-1){1'b0}}};

    logic armed_q;
    logic cmp_q;
    logic rise;

    assign rise = cmp && !cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            cmp_q     <= 1'b0;
            code_gray <= GRAY_FULL;
        end else begin
            cmp_q <= cmp;
            if (clear) begin
                armed_q   <= 1'b1;
                code_gray <= GRAY_FULL;
            end else if (capture_en && armed_q && rise) begin
                armed_q   <= 1'b0;
                code_gray <= gray_in;
            end
        end
    end
endmodule

// File: rtl/wc_gray_decode.sv
module wc_gray_decode #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0] gray,
    output logic [WIDTH-1:0] bin
);
    always_comb begin
        bin[WIDTH-1] = gray[WIDTH-1];
        for (int i = WIDTH - 2; i >= 0; i--) begin
            bin[i] = bin[i+1] ^ gray[i];
        end
    end
endmodule

// File: rtl/wilkinson_capture.sv
module wilkinson_capture
    import wc_pkg::*;
#(
    parameter int NCH   = 36,
    parameter int WIDTH = 12,
    parameter int SELW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ramp,
    input  logic [NCH-1:0]   cmp_in,
    input  logic [SELW-1:0]  rd_sel,
    output logic             ramp_active,
    output logic             end_of_ramp,
    output logic [WIDTH-1:0] count_gray,
    output logic [WIDTH-1:0] rd_code
);
    wc_state_e        state;
    logic             launch, advance, capture_en, at_max;
    logic [WIDTH-1:0] chan_gray [NCH];
    logic [WIDTH-1:0] sel_gray;
    logic [WIDTH-1:0] sel_bin;
    logic             sel_valid;

    wc_ramp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start_ramp),
        .count_at_max (at_max),
        .state        (state),
        .launch       (launch),
        .advance      (advance),
        .capture_en   (capture_en)
    );

    wc_gray_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .advance (advance),
        .gray    (count_gray),
        .at_max  (at_max)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        wc_channel_latch #(.WIDTH(WIDTH)) u_latch (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (launch),
            .capture_en (capture_en),
            .cmp        (cmp_in[ch]),
            .gray_in    (count_gray),
            .code_gray  (chan_gray[ch])
        );
    end

    always_comb begin
        sel_gray  = '0;
        sel_valid = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_sel == SELW'(i)) begin
                sel_gray  = chan_gray[i];
                sel_valid = 1'b1;
            end
        end
    end

    wc_gray_decode #(.WIDTH(WIDTH)) u_dec (
        .gray (sel_gray),
        .bin  (sel_bin)
    );

    assign rd_code     = sel_valid ? sel_bin : '0;
    assign ramp_active = (state == ST_RAMP);
    assign end_of_ramp = (state == ST_DONE);
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
    parameter int NCH   = 36,
    parameter int WIDTH = 12,
    parameter int SELW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_ramp,
    input logic [SELW-1:0]  rd_sel,
    input logic             ramp_active,
    input logic             end_of_ramp,
    input logic [WIDTH-1:0] count_gray,
    input logic [WIDTH-1:0] rd_code
);
    localparam logic [WIDTH-1:0] GRAY_FULL = {1'b1, {(WIDTH-1){1'b0}}};

    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ramp && !ramp_active |=> ramp_active && !end_of_ramp && count_gray == '0);

    assert_one_bit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_active && $past(ramp_active) && count_gray != GRAY_FULL
        |=> $countones(count_gray ^ $past(count_gray)) == 1 || !ramp_active);

    assert_stop_at_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_ramp |-> count_gray == GRAY_FULL);

    assert_finish_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_active && count_gray == GRAY_FULL |=> end_of_ramp && !ramp_active);

    assert_states_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ramp_active, end_of_ramp}));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_active && count_gray != GRAY_FULL |=> ramp_active);

    assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_ramp && !start_ramp
        |=> end_of_ramp && (rd_sel != $past(rd_sel) || rd_code == $past(rd_code)));
endmodule

bind wilkinson_capture wc_checker #(.NCH(NCH), .WIDTH(WIDTH), .SELW(SELW)) u_wc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_ramp  (start_ramp),
    .rd_sel      (rd_sel),
    .ramp_active (ramp_active),
    .end_of_ramp (end_of_ramp),
    .count_gray  (count_gray),
    .rd_code     (rd_code)
);

// File: tb/wilkinson_capture_bench.sv
`timescale 1ns/1ps
module wilkinson_capture_bench;
    localparam int NCH  = 5;
    localparam int W    = 5;
    localparam int SELW = 3;
    localparam int MAXV = (1 << W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_ramp = 1'b0;
    logic [NCH-1:0]  cmp_in = '0;
    logic [SELW-1:0] rd_sel = '0;
    logic            ramp_active, end_of_ramp;
    logic [W-1:0]    count_gray, rd_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wilkinson_capture #(.NCH(NCH), .WIDTH(W)) u_wilkinson_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_ramp  (start_ramp),
        .cmp_in      (cmp_in),
        .rd_sel      (rd_sel),
        .ramp_active (ramp_active),
        .end_of_ramp (end_of_ramp),
        .count_gray  (count_gray),
        .rd_code     (rd_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int gray_of(input int v);
        return v ^ (v >> 1);
    endfunction

    task automatic read_chan(input int ch, input int exp, input string req);
        rd_sel = SELW'(ch);
        #1;
        check(int'(rd_code) == exp, req, int'(rd_code), exp);
    endtask

    task automatic run_conv(input int t[NCH], input bit poke_start);
        @(negedge clk);
        start_ramp = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_ramp = 1'b0;
        for (int c = 0; c <= MAXV; c++) begin
            check(ramp_active && !end_of_ramp, "R2/R8 ramp_active", int'(ramp_active), 1);
            check(int'(count_gray) == gray_of(c), "R3 count_gray", int'(count_gray), gray_of(c));
            if (c == 0) read_chan(0, MAXV, "R2 code cleared at start");
            start_ramp = poke_start && (c == 10);
            for (int ch = 0; ch < NCH; ch++) begin
                cmp_in[ch] = (t[ch] >= 0) && (c == t[ch] || c == t[ch] + 4); // R6 second pulse
            end
            @(posedge clk);
            @(negedge clk);
            start_ramp = 1'b0;
        end
        cmp_in = '0;
        check(end_of_ramp && !ramp_active, "R4 end_of_ramp", int'(end_of_ramp), 1);
        check(int'(count_gray) == gray_of(MAXV), "R4 count held", int'(count_gray), gray_of(MAXV));
        for (int ch = 0; ch < (1 << SELW); ch++) begin
            int exp;
            if (ch >= NCH)      exp = 0;       // R10
            else if (t[ch] < 0) exp = MAXV;    // R7
            else                exp = t[ch];   // R5 R6
            read_chan(ch, exp, ch >= NCH ? "R10" : (t[ch] < 0 ? "R7" : "R5/R6"));
        end
        repeat (3) @(negedge clk);
        check(end_of_ramp, "R9 end held", int'(end_of_ramp), 1);
        read_chan(1, t[1] < 0 ? MAXV : t[1], "R9 code held");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!ramp_active && !end_of_ramp, "R1 idle", int'(ramp_active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ramp_active && !end_of_ramp, "R1 idle after release", int'(end_of_ramp), 0);
        for (int ch = 0; ch < NCH; ch++) read_chan(ch, MAXV, "R1 reset code");
        for (int t0 = 0; t0 <= MAXV; t0++) begin
            int t[NCH];
            t[0] = t0;
            t[1] = (t0 * 7 + 3) % (MAXV + 1);
            t[2] = MAXV - t0;
            t[3] = (t0 % 2 == 1) ? -1 : t0 / 2;
            t[4] = (t0 * 5) % (MAXV + 1);
            run_conv(t, (t0 % 2 == 0));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule